// File: doc/BRIEF.md
# Serial Memory Pin Ownership Arbiter

This block sits between an internal serial-memory engine and the four pins of an external serial non-volatile memory: clock, active-low select, data toward the memory, and data from the memory. By default the engine owns the pins. Software can take the pins over and drive them by hand through a small control register.

To take over, software sets an ownership-request bit and polls a grant bit. The arbiter waits until the engine reports that it is idle, and only then sets the grant. From that point the clock, select and data-out bits of the register drive the pins directly. The data-in pin is synchronised and can be read back through the same register. The engine is told to stay off the pins for as long as a request or a grant is active.

The arbiter never withdraws the grant by itself, because software may still be waiting for the memory to finish an internal program or erase cycle. Ownership goes back to the engine only when software clears the request bit.

Top module: `nvm_pin_arbiter`

## Requirements
- R1: While reset is asserted and right after it, the pins sit at their idle levels: clock 0, select 1, data-out 0. The request bit, the grant bit and the engine hold-off output are all 0.
- R2: While the request bit is set, the grant bit (register bit 5) rises in the first cycle after a clock edge at which the engine busy input was low. It stays clear for as long as busy is high.
- R3: Once the grant is set, it stays set for as long as the request bit stays set, whatever the busy input does.
- R4: Once the request bit (register bit 4) is cleared by a write, the grant clears at the next clock edge.
- R5: While the grant is set, the pins follow the stored register bits. Bit 0 drives the clock, bit 1 drives the active-low select and bit 2 drives data-out. A write becomes visible on the pins after the clock edge that captures it.
- R6: While the grant is clear and the engine busy input is high, the pins follow the engine's own clock, select and data-out inputs.
- R7: While the grant is clear and the engine is not busy, the pins hold their idle levels. Writes to register bits 0 to 2 have no effect on the pins in this state.
- R8: The engine hold-off output is high exactly when the request bit or the grant bit is set.
- R9: A register read returns the following, combinationally: the stored bits 0 to 2, the data-in pin after SYNC_STAGES flip-flops in bit 3, the request in bit 4 and the grant in bit 5, with all higher bits 0. Writes to bits 3 and 5 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | REG_W | Register write data |
| reg_rdata_o | output | REG_W | Register read data |
| eng_busy_i | input | 1 | The internal engine has an operation in progress |
| eng_sck_i | input | 1 | Clock from the engine |
| eng_cs_ni | input | 1 | Select from the engine, active low |
| eng_mosi_i | input | 1 | Data-out from the engine |
| eng_hold_o | output | 1 | The engine must not start new operations |
| nvm_sck_o | output | 1 | Memory clock pin |
| nvm_cs_no | output | 1 | Memory select pin, active low |
| nvm_mosi_o | output | 1 | Data pin toward the memory |
| nvm_miso_i | input | 1 | Data pin from the memory |

## Verification
A grant flop in the wrong state shows up at the pins in the same cycle. The pins either follow the register while the engine is mid-operation, or they fall back to idle while software is bit-banging. The grant bit in the read data shows the same fault in that cycle. A stale request or grant shows at once on the hold-off output. A data-in synchroniser of the wrong depth shifts the read-back of a toggled input by a whole cycle, so a cycle-exact comparison catches it within SYNC_STAGES+1 cycles of the toggle.

// File: rtl/nvm_arb_pkg.sv
`timescale 1ns/1ps
package nvm_arb_pkg;
  localparam int unsigned BIT_SCK  = 0;
  localparam int unsigned BIT_CSN  = 1;
  localparam int unsigned BIT_MOSI = 2;
  localparam int unsigned BIT_DIN  = 3;
  localparam int unsigned BIT_REQ  = 4;
  localparam int unsigned BIT_GNT  = 5;
  localparam int unsigned MIN_REG_W = BIT_GNT + 1;

  typedef struct packed {
    logic sck;
    logic cs_n;
    logic mosi;
  } pins_t;

  localparam pins_t PINS_IDLE = '{sck: 1'b0, cs_n: 1'b1, mosi: 1'b0};
endpackage

// File: rtl/nvm_arb_sync.sv
`timescale 1ns/1ps
module nvm_arb_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  if (STAGES == 0) begin : g_bypass
    assign q_o = d_i;
  end else begin : g_flops
    logic [STAGES-1:0] pipe_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pipe_q <= '0;
      else if (STAGES == 1) pipe_q <= d_i;
      else pipe_q <= {pipe_q[STAGES-2:0], d_i};
    end
    assign q_o = pipe_q[STAGES-1];
  end
endmodule

// File: rtl/nvm_arb_regfile.sv
`timescale 1ns/1ps
module nvm_arb_regfile
  import nvm_arb_pkg::*;
#(
  parameter int unsigned REG_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic             req_o,
  output pins_t            sw_pins_o
);
  logic  req_q;
  pins_t pins_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= 1'b0;
      pins_q <= PINS_IDLE;
    end else if (we_i) begin
      req_q       <= wdata_i[BIT_REQ];
      pins_q.sck  <= wdata_i[BIT_SCK];
      pins_q.cs_n <= wdata_i[BIT_CSN];
      pins_q.mosi <= wdata_i[BIT_MOSI];
    end
  end

  assign req_o     = req_q;
  assign sw_pins_o = pins_q;
endmodule

// File: rtl/nvm_arb_grant.sv
`timescale 1ns/1ps
module nvm_arb_grant (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic busy_i,
  output logic gnt_o,
  output logic hold_o
);
  logic gnt_q;

  // grant only from an idle engine; never revoked while request stays
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gnt_q <= 1'b0;
    else gnt_q <= req_i & (gnt_q | ~busy_i);
  end

  assign gnt_o  = gnt_q;
  assign hold_o = req_i | gnt_q;
endmodule

// File: rtl/nvm_arb_pinmux.sv
`timescale 1ns/1ps
module nvm_arb_pinmux
  import nvm_arb_pkg::*;
(
  input  logic  gnt_i,
  input  logic  busy_i,
  input  pins_t sw_i,
  input  pins_t eng_i,
  output pins_t pins_o
);
  always_comb begin
    if (gnt_i)       pins_o = sw_i;
    else if (busy_i) pins_o = eng_i;
    else             pins_o = PINS_IDLE;
  end
endmodule

// File: rtl/nvm_pin_arbiter.sv
`timescale 1ns/1ps
module nvm_pin_arbiter
  import nvm_arb_pkg::*;
#(
  parameter int unsigned REG_W       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_we_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  input  logic             eng_busy_i,
  input  logic             eng_sck_i,
  input  logic             eng_cs_ni,
  input  logic             eng_mosi_i,
  output logic             eng_hold_o,
  output logic             nvm_sck_o,
  output logic             nvm_cs_no,
  output logic             nvm_mosi_o,
  input  logic             nvm_miso_i
);
  initial begin
    if (REG_W < MIN_REG_W) $error("REG_W too small");
  end

  logic  req, gnt, din_s;
  pins_t sw_pins, eng_pins, pins;

  assign eng_pins = '{sck: eng_sck_i, cs_n: eng_cs_ni, mosi: eng_mosi_i};

  nvm_arb_regfile #(.REG_W(REG_W)) u_regs (
    .clk_i, .rst_ni, .we_i(reg_we_i), .wdata_i(reg_wdata_i),
    .req_o(req), .sw_pins_o(sw_pins)
  );

  nvm_arb_grant u_grant (
    .clk_i, .rst_ni, .req_i(req), .busy_i(eng_busy_i),
    .gnt_o(gnt), .hold_o(eng_hold_o)
  );

  nvm_arb_sync #(.STAGES(SYNC_STAGES)) u_din_sync (
    .clk_i, .rst_ni, .d_i(nvm_miso_i), .q_o(din_s)
  );

  nvm_arb_pinmux u_mux (
    .gnt_i(gnt), .busy_i(eng_busy_i), .sw_i(sw_pins), .eng_i(eng_pins),
    .pins_o(pins)
  );

  assign nvm_sck_o  = pins.sck;
  assign nvm_cs_no  = pins.cs_n;
  assign nvm_mosi_o = pins.mosi;

  always_comb begin
    reg_rdata_o           = '0;
    reg_rdata_o[BIT_SCK]  = sw_pins.sck;
    reg_rdata_o[BIT_CSN]  = sw_pins.cs_n;
    reg_rdata_o[BIT_MOSI] = sw_pins.mosi;
    reg_rdata_o[BIT_DIN]  = din_s;
    reg_rdata_o[BIT_REQ]  = req;
    reg_rdata_o[BIT_GNT]  = gnt;
  end
endmodule

// File: rtl/nvm_pin_arbiter_chk.sv
`timescale 1ns/1ps
module nvm_pin_arbiter_chk #(
  parameter int unsigned REG_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [REG_W-1:0] reg_rdata_o,
  input logic             eng_busy_i,
  input logic             eng_sck_i,
  input logic             eng_cs_ni,
  input logic             eng_mosi_i,
  input logic             eng_hold_o,
  input logic             nvm_sck_o,
  input logic             nvm_cs_no,
  input logic             nvm_mosi_o
);
  logic req, gnt;
  assign req = reg_rdata_o[4];
  assign gnt = reg_rdata_o[5];

  assert_gnt_from_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(gnt) |-> $past(req && !eng_busy_i));

  assert_gnt_kept_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt && req) |=> gnt);

  assert_gnt_released_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt && !req) |=> !gnt);

  assert_pins_follow_reg_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gnt |-> (nvm_sck_o == reg_rdata_o[0] && nvm_cs_no == reg_rdata_o[1]
             && nvm_mosi_o == reg_rdata_o[2]));

  assert_pins_follow_eng_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!gnt && eng_busy_i) |-> (nvm_sck_o == eng_sck_i && nvm_cs_no == eng_cs_ni
                              && nvm_mosi_o == eng_mosi_i));

  assert_pins_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!gnt && !eng_busy_i) |-> (!nvm_sck_o && nvm_cs_no && !nvm_mosi_o));

  assert_hold_off_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_hold_o == (req || gnt));
endmodule

bind nvm_pin_arbiter nvm_pin_arbiter_chk #(.REG_W(REG_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .reg_rdata_o(reg_rdata_o),
  .eng_busy_i(eng_busy_i), .eng_sck_i(eng_sck_i), .eng_cs_ni(eng_cs_ni),
  .eng_mosi_i(eng_mosi_i), .eng_hold_o(eng_hold_o), .nvm_sck_o(nvm_sck_o),
  .nvm_cs_no(nvm_cs_no), .nvm_mosi_o(nvm_mosi_o)
);

// File: tb/nvm_pin_arbiter_tb_top.sv
`timescale 1ns/1ps
module nvm_pin_arbiter_tb_top;
  localparam int REG_W = 8;
  localparam int SYNC = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic we = 1'b0;
  logic [REG_W-1:0] wdata = '0;
  logic [REG_W-1:0] rdata;
  logic busy = 1'b0, e_sck = 1'b0, e_csn = 1'b1, e_mosi = 1'b0, miso = 1'b0;
  logic hold, p_sck, p_csn, p_mosi;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  // reference state
  bit m_req, m_gnt, m_sck, m_csn, m_mosi;
  bit [SYNC-1:0] m_sync;

  always #5 clk = ~clk;

  nvm_pin_arbiter #(.REG_W(REG_W), .SYNC_STAGES(SYNC)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .eng_busy_i(busy), .eng_sck_i(e_sck),
    .eng_cs_ni(e_csn), .eng_mosi_i(e_mosi), .eng_hold_o(hold),
    .nvm_sck_o(p_sck), .nvm_cs_no(p_csn), .nvm_mosi_o(p_mosi),
    .nvm_miso_i(miso)
  );

  function automatic logic [2:0] exp_pins();
    if (m_gnt) return {m_mosi, m_csn, m_sck};
    if (busy)  return {e_mosi, e_csn, e_sck};
    return 3'b010;
  endfunction

  function automatic logic [REG_W-1:0] exp_rdata();
    logic [REG_W-1:0] r = '0;
    r[0] = m_sck; r[1] = m_csn; r[2] = m_mosi;
    r[3] = m_sync[SYNC-1]; r[4] = m_req; r[5] = m_gnt;
    return r;
  endfunction

  task automatic check(string tag, logic [REG_W-1:0] act, logic [REG_W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all(string grant_tag);
    string pin_tag;
    pin_tag = m_gnt ? "R5" : (busy ? "R6" : "R7");
    check(grant_tag, REG_W'(rdata[5]), REG_W'(m_gnt));
    check(pin_tag, REG_W'({p_mosi, p_csn, p_sck}), REG_W'(exp_pins()));
    check("R8", REG_W'(hold), REG_W'(m_req | m_gnt));
    check("R9", rdata, exp_rdata());
  endtask

  task automatic cyc(bit w, logic [REG_W-1:0] d, bit b, bit es, bit ec, bit em, bit mi);
    bit prev_req, prev_gnt, prev_busy;
    string gtag;
    @(negedge clk);
    we = w; wdata = d; busy = b; e_sck = es; e_csn = ec; e_mosi = em; miso = mi;
    prev_req = m_req; prev_gnt = m_gnt; prev_busy = b;
    @(posedge clk);
    m_gnt = prev_req & (prev_gnt | ~prev_busy);
    if (SYNC > 1) m_sync = {m_sync[SYNC-2:0], mi};
    else m_sync = SYNC'(mi);
    if (w) begin
      m_req = d[4]; m_sck = d[0]; m_csn = d[1]; m_mosi = d[2];
    end
    #2;
    if (prev_gnt && !prev_req) gtag = "R4";
    else if (prev_gnt) gtag = "R3";
    else gtag = "R2";
    check_all(gtag);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    m_req = 0; m_gnt = 0; m_sck = 0; m_csn = 1; m_mosi = 0; m_sync = '0;
    #22;
    // R1: reset levels
    check("R1", REG_W'({hold, p_mosi, p_csn, p_sck}), REG_W'(4'b0010));
    check("R1", rdata, REG_W'(8'h02));
    @(negedge clk); rst_n = 1'b1;
    #1 check("R1", REG_W'({hold, rdata[5:4]}), '0);

    // R2: request while busy -> withheld
    cyc(1, 8'h12, 1, 1, 0, 1, 0);
    for (int i = 0; i < 4; i++) cyc(0, 0, 1, i[0], 0, 1, 1);
    cyc(0, 0, 0, 0, 1, 0, 1);       // busy drops; grant next edge
    cyc(0, 0, 1, 1, 0, 1, 0);       // R3: granted despite busy
    // R5: bit-bang pins
    cyc(1, 8'h15, 1, 0, 1, 0, 1);
    cyc(1, 8'h13, 0, 0, 1, 0, 0);
    cyc(1, 8'h3f, 1, 0, 1, 0, 1);   // bits 3,5 ignored (R9)
    // R4: drop request
    cyc(1, 8'h07, 0, 0, 1, 0, 1);
    cyc(0, 0, 0, 0, 1, 0, 1);
    // R7: writes with no request leave pins idle
    cyc(1, 8'h05, 0, 0, 1, 0, 0);
    cyc(0, 0, 0, 0, 1, 0, 0);
    // R6: engine drives while busy
    cyc(0, 0, 1, 1, 0, 1, 0);
    cyc(0, 0, 1, 0, 0, 1, 1);

    for (int i = 0; i < 3000; i++) begin
      bit w;
      logic [REG_W-1:0] d;
      w = ($urandom % 5) == 0;
      d = REG_W'($urandom);
      d[4] = ($urandom % 10) < 6;
      cyc(w, d, ($urandom % 10) < 3, 1'($urandom), 1'($urandom),
          1'($urandom), 1'($urandom));
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule